// File: doc/BRIEF.md
# Sensor Result Tracker with Alarms

This block sits behind a multi-channel sensor front end and turns its stream of conversion results into a readable register bank. Each result arrives as a one-cycle strobe with a channel index and a sample value. For every channel that software has switched on, the block stores the latest sample and tracks the smallest and largest samples since the last statistics reset. It also raises a sticky new-data flag and compares the sample against a programmable window made of a lower and an upper threshold. A sample outside the window raises a sticky alarm flag.

Five interrupt status bits are folded into one interrupt line. Four of them follow new data on channels that software selects. The fifth follows any alarm. Each status bit can be masked. Every configuration register is write-protected until a 32-bit key is written to the key register, and writing any other value to that register turns the protection back on.

Software reaches the block through a single-cycle register port. Reads are combinational and writes take effect on the clock edge. The channel count is a parameter (1 to 160), and so is the sample width (up to 32 bits).

Top module: `sens_track`

## Requirements
- R1: A strobe on an enabled channel c loads the sample into that channel's current register, read at address 0x100 + 8*c + 0, one clock after the strobe.
- R2: Channel c's minimum (offset 1) and maximum (offset 2) hold the smallest and largest samples taken since reset or since the last statistics reset. Reset sets the minimum to all ones and the maximum to zero. Writing 1 to bit 0 of address 0x001 restores those values. If a strobe on c arrives in the same cycle as a statistics reset, both registers load that sample.
- R3: Each strobe on an enabled channel c sets new-data flag bit c%32 of word 0x010 + c/32. Writing 1 to a flag bit clears it, and a set in the same cycle takes priority over the clear.
- R4: Channel enable bits sit at bit c%32 of word 0x020 + c/32 and reset to 0. A strobe on a disabled channel, or with an index of NCH or above, changes no sample, flag or status bit.
- R5: Alarm enable bits sit at bit c%32 of word 0x030 + c/32. An enabled channel whose alarm is enabled sets sticky alarm flag bit c%32 of word 0x040 + c/32 when its sample is strictly below its lower threshold (offset 3, reset 0) or strictly above its upper threshold (offset 4, reset all ones). A sample equal to either threshold raises no alarm. Writing 1 to an alarm flag bit clears it.
- R6: Writing 0xF9E8D7C6 to address 0x000 unlocks configuration, and bit 0 of that address then reads 1. Writing any other value to 0x000 locks it again, and the block comes out of reset locked. While the block is locked, writes to the enable words, alarm enable words, thresholds, source select (0x006, 0x007), 0x004 and 0x005 are ignored.
- R7: Address 0x006 holds four 8-bit channel indices, with slot i in bits 8i+7:8i. Bit i of address 0x007 marks slot i as valid. A strobe on an enabled channel that equals a valid slot's index sets interrupt status bit i.
- R8: Interrupt status bit 4 is set whenever a sample sets any alarm flag. The status register at 0x002 is sticky, and writing 1 to a bit clears it.
- R9: The mask register at 0x003 (bits 4:0) resets to all ones. Writing 1s to 0x004 clears those mask bits, and writing 1s to 0x005 sets them. The irq output is high exactly when some status bit is set and not masked.
- R10: A read of any address that is not mapped returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_vld | input | 1 | Conversion result strobe |
| res_ch | input | 8 | Channel index of the result |
| res_val | input | DW | Sample value of the result |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 12 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The assertions assume that register writes and result strobes are single-cycle pulses sampled on the rising clock edge. The flag-hold properties assume that a flag can be cleared only on a cycle in which the register port writes, so they are conditioned on reg_we being low. The bench drives every input on the falling edge and keeps reg_we low on the strobe cycles it uses to check the hold behaviour. It drives channel indices both inside and outside the configured channel count. It sets the thresholds so that samples land exactly on each edge of the window and one code beyond it.

// File: rtl/sens_track_pkg.sv
package sens_track_pkg;
  localparam int AW   = 12;
  localparam int IW   = 8;
  localparam int NSRC = 4;
  localparam int NIRQ = NSRC + 1;

  localparam logic [AW-1:0] A_KEY    = 12'h000;
  localparam logic [AW-1:0] A_CTRL   = 12'h001;
  localparam logic [AW-1:0] A_ISR    = 12'h002;
  localparam logic [AW-1:0] A_MASK   = 12'h003;
  localparam logic [AW-1:0] A_IEN    = 12'h004;
  localparam logic [AW-1:0] A_IDIS   = 12'h005;
  localparam logic [AW-1:0] A_SRCIDX = 12'h006;
  localparam logic [AW-1:0] A_SRCVLD = 12'h007;
  localparam logic [AW-1:0] B_NEW    = 12'h010;
  localparam logic [AW-1:0] B_CHEN   = 12'h020;
  localparam logic [AW-1:0] B_AEN    = 12'h030;
  localparam logic [AW-1:0] B_AFLG   = 12'h040;
  localparam logic [AW-1:0] B_CHAN   = 12'h100;

  localparam logic [2:0] K_CUR = 3'd0;
  localparam logic [2:0] K_MIN = 3'd1;
  localparam logic [2:0] K_MAX = 3'd2;
  localparam logic [2:0] K_LO  = 3'd3;
  localparam logic [2:0] K_HI  = 3'd4;

  // window test: strictly outside [lo, hi]
  function automatic logic out_of_window(logic [31:0] s, logic [31:0] lo, logic [31:0] hi);
    return (s < lo) || (s > hi);
  endfunction

  function automatic logic [31:0] pick_lower(logic [31:0] a, logic [31:0] b);
    return (b < a) ? b : a;
  endfunction

  function automatic logic [31:0] pick_upper(logic [31:0] a, logic [31:0] b);
    return (b > a) ? b : a;
  endfunction
endpackage

// File: rtl/sens_track_lock.sv
module sens_track_lock #(
  parameter logic [31:0] KEY = 32'hF9E8D7C6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_val,
  output logic        unlocked
);
  always_ff @(posedge clk) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_we) unlocked <= (key_val == KEY);
  end
endmodule

// File: rtl/sens_track_chan.sv
module sens_track_chan
  import sens_track_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          clr_mm,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] wval,
  output logic [DW-1:0] cur,
  output logic [DW-1:0] mn,
  output logic [DW-1:0] mx,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi,
  output logic          viol
);
  logic [DW-1:0] base_mn, base_mx;

  always_comb begin
    base_mn = clr_mm ? '1 : mn;
    base_mx = clr_mm ? '0 : mx;
    viol    = out_of_window(32'(sample), 32'(lo), 32'(hi));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      mn  <= '1;
      mx  <= '0;
      lo  <= '0;
      hi  <= '1;
    end else begin
      if (take) cur <= sample;
      if (take || clr_mm) begin
        mn <= take ? DW'(pick_lower(32'(base_mn), 32'(sample))) : base_mn;
        mx <= take ? DW'(pick_upper(32'(base_mx), 32'(sample))) : base_mx;
      end
      if (wr_lo) lo <= wval;
      if (wr_hi) hi <= wval;
    end
  end
endmodule

// File: rtl/sens_track_irq.sv
module sens_track_irq #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic         dis_we,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] isr,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] clr_bits;

  always_comb begin
    clr_bits = clr_we ? wbits : '0;
    irq      = |(isr & ~mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr  <= '0;
      mask <= '1;
    end else begin
      isr <= (isr & ~clr_bits) | ev;
      if (en_we)       mask <= mask & ~wbits;
      else if (dis_we) mask <= mask | wbits;
    end
  end
endmodule

// File: rtl/sens_track.sv
module sens_track
  import sens_track_pkg::*;
#(
  parameter int          NCH = 8,
  parameter int          DW  = 16,
  parameter logic [31:0] KEY = 32'hF9E8D7C6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_vld,
  input  logic [IW-1:0] res_ch,
  input  logic [DW-1:0] res_val,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  localparam int NW = (NCH + 31) / 32;
  localparam int NB = NW * 32;

  // named internal events
  logic             unlocked;
  logic             cfg_we;
  logic             wr_key;
  logic             clr_mm;
  logic [NCH-1:0]   take;
  logic             take_any;
  logic [NCH-1:0]   viol;
  logic [NCH-1:0]   aset;
  logic [NIRQ-1:0]  irq_ev;
  logic [NIRQ-1:0]  isr, mask;

  logic [NB-1:0] vmask, newf, chen, aen, aflg;
  logic [NB-1:0] new_clr, af_clr;

  logic [DW-1:0] cur_a [NCH];
  logic [DW-1:0] mn_a  [NCH];
  logic [DW-1:0] mx_a  [NCH];
  logic [DW-1:0] lo_a  [NCH];
  logic [DW-1:0] hi_a  [NCH];
  logic [NCH*DW-1:0] cur_flat, mn_flat, mx_flat, lo_flat, hi_flat;

  logic [IW-1:0]   src_idx [NSRC];
  logic [NSRC-1:0] src_vld;

  logic [AW-1:0] ch_off;
  logic          in_chan;
  logic [AW-4:0] ch_sel;
  logic [2:0]    ch_fld;

  sens_track_lock #(.KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .key_we(wr_key), .key_val(reg_wdata), .unlocked(unlocked)
  );

  always_comb begin
    wr_key   = reg_we && (reg_addr == A_KEY);
    cfg_we   = reg_we && unlocked;
    clr_mm   = reg_we && (reg_addr == A_CTRL) && reg_wdata[0];
    ch_off   = reg_addr - B_CHAN;
    in_chan  = (reg_addr >= B_CHAN) && (ch_off < AW'(NCH * 8));
    ch_sel   = ch_off[AW-1:3];
    ch_fld   = ch_off[2:0];
    take_any = |take;
    for (int i = 0; i < NB; i++) vmask[i] = (i < NCH);
    for (int w = 0; w < NW; w++) begin
      new_clr[w*32 +: 32] = (reg_we && reg_addr == B_NEW  + AW'(w)) ? reg_wdata : 32'h0;
      af_clr [w*32 +: 32] = (reg_we && reg_addr == B_AFLG + AW'(w)) ? reg_wdata : 32'h0;
    end
  end

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic wr_lo_c, wr_hi_c;
      assign take[c]  = res_vld && (res_ch == IW'(c)) && chen[c];
      assign wr_lo_c  = cfg_we && in_chan && (ch_sel == (AW-3)'(c)) && (ch_fld == K_LO);
      assign wr_hi_c  = cfg_we && in_chan && (ch_sel == (AW-3)'(c)) && (ch_fld == K_HI);
      assign aset[c]  = take[c] && aen[c] && viol[c];

      sens_track_chan #(.DW(DW)) u_chan (
        .clk(clk), .rst_n(rst_n), .take(take[c]), .clr_mm(clr_mm),
        .wr_lo(wr_lo_c), .wr_hi(wr_hi_c), .sample(res_val), .wval(reg_wdata[DW-1:0]),
        .cur(cur_a[c]), .mn(mn_a[c]), .mx(mx_a[c]), .lo(lo_a[c]), .hi(hi_a[c]),
        .viol(viol[c])
      );

      assign cur_flat[c*DW +: DW] = cur_a[c];
      assign mn_flat [c*DW +: DW] = mn_a[c];
      assign mx_flat [c*DW +: DW] = mx_a[c];
      assign lo_flat [c*DW +: DW] = lo_a[c];
      assign hi_flat [c*DW +: DW] = hi_a[c];
    end

    for (c = 0; c < NSRC; c++) begin : g_src
      assign irq_ev[c] = src_vld[c] && take_any && (res_ch == src_idx[c]);
    end
  endgenerate

  assign irq_ev[NSRC] = |aset;

  // flag and enable words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      newf <= '0;
      aflg <= '0;
      chen <= '0;
      aen  <= '0;
    end else begin
      newf <= (newf & ~new_clr) | (NB'(take) & vmask);
      aflg <= (aflg & ~af_clr)  | (NB'(aset) & vmask);
      for (int w = 0; w < NW; w++) begin
        if (cfg_we && reg_addr == B_CHEN + AW'(w))
          chen[w*32 +: 32] <= reg_wdata & vmask[w*32 +: 32];
        if (cfg_we && reg_addr == B_AEN + AW'(w))
          aen[w*32 +: 32] <= reg_wdata & vmask[w*32 +: 32];
      end
    end
  end

  // interrupt source selection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_vld <= '0;
      for (int i = 0; i < NSRC; i++) src_idx[i] <= '0;
    end else begin
      if (cfg_we && reg_addr == A_SRCIDX)
        for (int i = 0; i < NSRC; i++) src_idx[i] <= reg_wdata[i*8 +: IW];
      if (cfg_we && reg_addr == A_SRCVLD)
        src_vld <= reg_wdata[NSRC-1:0];
    end
  end

  sens_track_irq #(.N(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(irq_ev),
    .clr_we(reg_we && reg_addr == A_ISR),
    .en_we(cfg_we && reg_addr == A_IEN),
    .dis_we(cfg_we && reg_addr == A_IDIS),
    .wbits(reg_wdata[NIRQ-1:0]),
    .isr(isr), .mask(mask), .irq(irq)
  );

  // read mux
  always_comb begin
    reg_rdata = 32'h0;
    if (reg_addr == A_KEY)    reg_rdata = {31'h0, unlocked};
    if (reg_addr == A_ISR)    reg_rdata = 32'(isr);
    if (reg_addr == A_MASK)   reg_rdata = 32'(mask);
    if (reg_addr == A_SRCVLD) reg_rdata = 32'(src_vld);
    if (reg_addr == A_SRCIDX)
      for (int i = 0; i < NSRC; i++) reg_rdata[i*8 +: 8] = 8'(src_idx[i]);
    for (int w = 0; w < NW; w++) begin
      if (reg_addr == B_NEW  + AW'(w)) reg_rdata = newf[w*32 +: 32];
      if (reg_addr == B_CHEN + AW'(w)) reg_rdata = chen[w*32 +: 32];
      if (reg_addr == B_AEN  + AW'(w)) reg_rdata = aen [w*32 +: 32];
      if (reg_addr == B_AFLG + AW'(w)) reg_rdata = aflg[w*32 +: 32];
    end
    if (in_chan)
      for (int i = 0; i < NCH; i++)
        if (ch_sel == (AW-3)'(i))
          case (ch_fld)
            K_CUR:   reg_rdata = 32'(cur_a[i]);
            K_MIN:   reg_rdata = 32'(mn_a[i]);
            K_MAX:   reg_rdata = 32'(mx_a[i]);
            K_LO:    reg_rdata = 32'(lo_a[i]);
            K_HI:    reg_rdata = 32'(hi_a[i]);
            default: reg_rdata = 32'h0;
          endcase
  end
endmodule

// File: rtl/sens_track_chk.sv
module sens_track_chk #(
  parameter int NCH = 8,
  parameter int DW  = 16,
  parameter int NI  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_vld,
  input logic              reg_we,
  input logic [DW-1:0]     res_val,
  input logic [NCH-1:0]    take,
  input logic [NCH-1:0]    newf,
  input logic [NCH-1:0]    aflg,
  input logic [NCH*DW-1:0] cur_flat,
  input logic [NCH*DW-1:0] mn_flat,
  input logic [NCH*DW-1:0] mx_flat,
  input logic [NCH*DW-1:0] lo_flat,
  input logic [NCH*DW-1:0] hi_flat,
  input logic              unlocked,
  input logic [NI-1:0]     isr,
  input logic [NI-1:0]     mask,
  input logic              irq
);
  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_a
      AST_CUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        take[c] |=> cur_flat[c*DW +: DW] == $past(res_val)); // R1
      AST_MIN_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        take[c] |=> (mn_flat[c*DW +: DW] <= $past(res_val)) && (mx_flat[c*DW +: DW] >= $past(res_val))); // R2
      AST_NEW_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        take[c] |=> newf[c]); // R3
      AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        aflg[c] && !reg_we |=> aflg[c]); // R5
    end
  endgenerate

  AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && (take == '0) && !reg_we |=> $stable(newf) && $stable(aflg)); // R4
  AST_LOCKED_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && reg_we |=> $stable(lo_flat) && $stable(hi_flat) && $stable(mask)); // R6
  AST_ISR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((isr & $past(isr)) == $past(isr))); // R8
  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq); // R9
endmodule

bind sens_track sens_track_chk #(.NCH(NCH), .DW(DW), .NI(sens_track_pkg::NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .reg_we(reg_we), .res_val(res_val),
  .take(take), .newf(newf[NCH-1:0]), .aflg(aflg[NCH-1:0]),
  .cur_flat(cur_flat), .mn_flat(mn_flat), .mx_flat(mx_flat),
  .lo_flat(lo_flat), .hi_flat(hi_flat), .unlocked(unlocked),
  .isr(isr), .mask(mask), .irq(irq)
);

// File: tb/sens_track_tb.sv
module sens_track_tb;
  localparam int NCH = 8;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_vld = 1'b0;
  logic [7:0]    res_ch = '0;
  logic [DW-1:0] res_val = '0;
  logic          reg_we = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int cur_m [NCH];
  int min_m [NCH];
  int max_m [NCH];

  sens_track #(.NCH(NCH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_ch(res_ch), .res_val(res_val),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [11:0] ch_addr(int ch, int fld);
    return 12'(256 + ch * 8 + fld);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rchk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic strobe(int ch, int v);
    @(negedge clk);
    res_vld = 1'b1; res_ch = 8'(ch); res_val = DW'(v);
    @(negedge clk);
    res_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rchk("R9 mask reset", 12'h003, 32'h1F);
    chk("R9 irq reset", 32'(irq), 0);
    rchk("R2 min reset", ch_addr(0, 1), 32'hFFFF);
    rchk("R2 max reset", ch_addr(0, 2), 32'h0);
    rchk("R6 locked at reset", 12'h000, 32'h0);
    rchk("R3 flags reset", 12'h010, 32'h0);

    // locked: config write ignored
    wr(12'h020, 32'hFF);
    rchk("R6 locked chen write", 12'h020, 32'h0);
    wr(12'h004, 32'h1F);
    rchk("R6 locked ien write", 12'h003, 32'h1F);

    // disabled channel ignored
    strobe(2, 1234);
    rchk("R4 disabled cur", ch_addr(2, 0), 32'h0);
    rchk("R4 disabled flag", 12'h010, 32'h0);

    // unlock, enable all
    wr(12'h000, 32'hF9E8D7C6);
    rchk("R6 unlocked", 12'h000, 32'h1);
    wr(12'h020, 32'hFFFF_FFFF);
    rchk("R4 chen masked to NCH", 12'h020, 32'hFF);

    // sweep: every channel, three samples each
    for (int ch = 0; ch < NCH; ch++) begin
      cur_m[ch] = 0; min_m[ch] = 'hFFFF; max_m[ch] = 0;
    end
    for (int k = 0; k < 3; k++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        int s;
        s = (ch * 7919 + k * 20011 + 13) % 65536;
        strobe(ch, s);
        cur_m[ch] = s;
        if (s < min_m[ch]) min_m[ch] = s;
        if (s > max_m[ch]) max_m[ch] = s;
        rchk("R1 current", ch_addr(ch, 0), 32'(cur_m[ch]));
        rchk("R2 minimum", ch_addr(ch, 1), 32'(min_m[ch]));
        rchk("R2 maximum", ch_addr(ch, 2), 32'(max_m[ch]));
      end
    end
    rchk("R3 all flags", 12'h010, 32'hFF);
    wr(12'h010, 32'h04);
    rchk("R3 w1c", 12'h010, 32'hFB);

    // out-of-range index
    strobe(8, 77);
    strobe(200, 77);
    rchk("R4 out of range flags", 12'h010, 32'hFB);
    rchk("R4 out of range isr", 12'h002, 32'h0);

    // statistics reset
    wr(12'h001, 32'h1);
    rchk("R2 stat reset min", ch_addr(5, 1), 32'hFFFF);
    rchk("R2 stat reset max", ch_addr(5, 2), 32'h0);
    rchk("R1 stat reset keeps cur", ch_addr(5, 0), 32'(cur_m[5]));
    strobe(5, 4321);
    rchk("R2 first after reset min", ch_addr(5, 1), 32'd4321);
    rchk("R2 first after reset max", ch_addr(5, 2), 32'd4321);

    // alarm window on channel 3
    wr(ch_addr(3, 3), 32'd100);
    wr(ch_addr(3, 4), 32'd200);
    wr(12'h030, 32'h08);
    strobe(3, 100);
    rchk("R5 at lower no alarm", 12'h040, 32'h0);
    strobe(3, 200);
    rchk("R5 at upper no alarm", 12'h040, 32'h0);
    rchk("R8 no alarm isr", 12'h002, 32'h0);
    strobe(3, 201);
    rchk("R5 above upper", 12'h040, 32'h08);
    rchk("R8 alarm isr", 12'h002, 32'h10);
    strobe(3, 150);
    rchk("R5 sticky", 12'h040, 32'h08);
    wr(12'h040, 32'h08);
    rchk("R5 w1c", 12'h040, 32'h0);
    strobe(3, 99);
    rchk("R5 below lower", 12'h040, 32'h08);
    strobe(4, 5);
    rchk("R5 alarm disabled chan", 12'h040, 32'h08);
    wr(12'h002, 32'h10);
    rchk("R8 isr w1c", 12'h002, 32'h0);

    // source select and mask
    wr(12'h006, 32'h0000_0006);
    wr(12'h007, 32'h1);
    rchk("R7 srcidx read", 12'h006, 32'h6);
    strobe(2, 10);
    rchk("R7 other channel", 12'h002, 32'h0);
    strobe(6, 10);
    rchk("R7 selected channel", 12'h002, 32'h1);
    chk("R9 masked irq", 32'(irq), 0);
    wr(12'h004, 32'h01);
    rchk("R9 mask after enable", 12'h003, 32'h1E);
    chk("R9 irq unmasked", 32'(irq), 1);
    wr(12'h005, 32'h01);
    chk("R9 irq remasked", 32'(irq), 0);
    wr(12'h004, 32'h01);
    wr(12'h002, 32'h01);
    chk("R9 irq after w1c", 32'(irq), 0);

    // relock
    wr(12'h000, 32'h1234_5678);
    rchk("R6 relocked", 12'h000, 32'h0);
    wr(ch_addr(0, 3), 32'd55);
    rchk("R6 locked threshold", ch_addr(0, 3), 32'h0);
    wr(12'h007, 32'hF);
    rchk("R6 locked srcvld", 12'h007, 32'h1);

    // unmapped
    rchk("R10 unmapped", 12'h0FF, 32'h0);
    rchk("R10 chan gap", ch_addr(1, 6), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule